// File: doc/BRIEF.md
# Requester-Priority Memory Access Arbiter

This block decides which of several clients may use one shared video-memory port. Each client raises a request and, with it, a priority value of its own choosing. The client may change that value at any time, for example as its buffer fills or drains. One client, the dual client, has two independent access kinds. Each kind has its own request and its own priority, and the arbiter folds the two into one candidate for that client.

A grant is chosen only at a decision point. A decision point is any clock edge while the port is idle, or the edge at which the memory side pulses `xfer_done` to end the running transfer. No running transfer is ever pre-empted. At each decision the client that was served most recently is left out of the choice. As a result, two high-priority clients that keep requesting take the port in turns. Lower-priority clients get the port only when one of those two is quiet. If the most recently served client is the only one asking, it is granted again so that the port does not sit idle. Bandwidth is not split into fixed time slices.

Top module: `vram_prio_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `gnt` is all zeros and `gnt_alt` is 0.
- R2: `gnt` never has more than one bit set. Bit i set means client i owns the port.
- R3: While `gnt` is non-zero and `xfer_done` is low, `gnt` and `gnt_alt` keep their values in the next cycle, whatever the requests and priorities do. No running transfer is pre-empted.
- R4: At an edge with `xfer_done` high, the new grant appears in the next cycle and goes to the requesting client with the highest priority, compared using the values present at that edge. Priority is an unsigned value of `PW` bits; a larger value is more urgent. Client i's priority is `prio[i*PW +: PW]`.
- R5: Among eligible clients with equal priority, the one with the lowest index wins.
- R6: The most recently granted client is excluded from the next decision while any other client is requesting. When two clients keep requesting with the two highest priorities, the grant alternates between them.
- R7: If the most recently granted client is the only one requesting at a decision, it is granted again.
- R8: While `gnt` is zero, a request is granted in the cycle after the edge at which it is first seen. If no client is requesting at a decision, `gnt` becomes zero.
- R9: The dual client (index `DUAL`) requests when `req[DUAL]` or `alt_req` is high. Its priority is the higher of its requesting kinds. When both kinds request with equal priority, the primary kind wins. `gnt_alt` is 1 exactly when that client is granted for the alternate kind.
- R10: A pulse on `xfer_done` while `gnt` is zero and no client is requesting leaves `gnt` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request level, one bit per client (primary kind for the dual client) |
| prio | input | N*PW | Priority of each client, packed with client 0 in the least significant bits |
| alt_req | input | 1 | Request for the alternate access kind of the dual client |
| alt_prio | input | PW | Priority of the alternate access kind |
| xfer_done | input | 1 | One-cycle pulse from the memory side marking the end of the running transfer |
| gnt | output | N | One-hot grant, registered |
| gnt_alt | output | 1 | The dual client's grant is for its alternate kind |

## Verification
The hardest case to reach from the ports is a decision where exclusion, the fallback to the excluded client, and the dual client's merged priority all matter in the same edge. For example, the dual client was served last and is now the only one asking, through its alternate kind alone. Directed sequences first build up a known "last served" history with chosen `xfer_done` pulses. They then change priorities during a running transfer so that the outcome at the next decision depends on values sampled only at that edge. A random phase follows, with a behavioural model of the decision compared against the outputs on every cycle.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  // Width of a client index; at least one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/arb_req_merge.sv
// Folds the dual client's two access kinds into one candidate per client.
module arb_req_merge #(
  parameter int N    = 4,
  parameter int PW   = 3,
  parameter int DUAL = 3
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  input  logic            alt_req,
  input  logic [PW-1:0]   alt_prio,
  output logic [N-1:0]    eff_req,
  output logic [N*PW-1:0] eff_prio,
  output logic            alt_pick
);
  for (genvar i = 0; i < N; i++) begin : g_client
    if (i == DUAL) begin : g_dual
      logic [PW-1:0] pri_p;
      logic          use_alt;
      assign pri_p   = prio[i*PW +: PW];
      // primary kind wins a tie
      assign use_alt = alt_req && (!req[i] || (alt_prio > pri_p));
      assign eff_req[i]            = req[i] | alt_req;
      assign eff_prio[i*PW +: PW]  = use_alt ? alt_prio : pri_p;
      assign alt_pick              = use_alt;
    end else begin : g_plain
      assign eff_req[i]            = req[i];
      assign eff_prio[i*PW +: PW]  = prio[i*PW +: PW];
    end
  end
endmodule

// File: rtl/arb_pick.sv
// Highest-priority selection with exclusion of one client and fallback to it.
module arb_pick #(
  parameter int N  = 4,
  parameter int PW = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]    eff_req,
  input  logic [N*PW-1:0] eff_prio,
  input  logic            excl_vld,
  input  logic [IW-1:0]   excl_idx,
  output logic            win_vld,
  output logic [IW-1:0]   win_idx
);
  logic [N-1:0]  elig;
  logic [N-1:0]  pool;
  logic [PW-1:0] best_p;

  always_comb begin
    elig = eff_req;
    for (int i = 0; i < N; i++) begin
      if (excl_vld && (excl_idx == IW'(i))) elig[i] = 1'b0;
    end
    // nobody else asking: the excluded client may take the port again
    pool    = (|elig) ? elig : eff_req;
    win_vld = 1'b0;
    win_idx = '0;
    best_p  = '0;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lowest index on ties
      if (pool[i] && (!win_vld || (eff_prio[i*PW +: PW] > best_p))) begin
        win_vld = 1'b1;
        win_idx = IW'(i);
        best_p  = eff_prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/vram_prio_arbiter.sv
module vram_prio_arbiter #(
  parameter int N    = 4,
  parameter int PW   = 3,
  parameter int DUAL = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  input  logic            alt_req,
  input  logic [PW-1:0]   alt_prio,
  input  logic            xfer_done,
  output logic [N-1:0]    gnt,
  output logic            gnt_alt
);
  localparam int IW = vram_arb_pkg::idx_width(N);

  logic [N-1:0]    eff_req;
  logic [N*PW-1:0] eff_prio;
  logic            alt_pick;
  logic            win_vld;
  logic [IW-1:0]   win_idx;
  logic [N-1:0]    gnt_q;
  logic            gnt_alt_q;
  logic [IW-1:0]   last_idx;
  logic            last_vld;
  logic            decide;

  arb_req_merge #(.N(N), .PW(PW), .DUAL(DUAL)) u_merge (
    .req      (req),
    .prio     (prio),
    .alt_req  (alt_req),
    .alt_prio (alt_prio),
    .eff_req  (eff_req),
    .eff_prio (eff_prio),
    .alt_pick (alt_pick)
  );

  arb_pick #(.N(N), .PW(PW), .IW(IW)) u_pick (
    .eff_req  (eff_req),
    .eff_prio (eff_prio),
    .excl_vld (last_vld),
    .excl_idx (last_idx),
    .win_vld  (win_vld),
    .win_idx  (win_idx)
  );

  // decisions happen while idle or when the running transfer ends
  assign decide = ~(|gnt_q) | xfer_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q     <= '0;
      gnt_alt_q <= 1'b0;
      last_idx  <= '0;
      last_vld  <= 1'b0;
    end else if (decide) begin
      gnt_q     <= win_vld ? (N'(1) << win_idx) : '0;
      gnt_alt_q <= win_vld && (win_idx == IW'(DUAL)) && alt_pick;
      if (win_vld) begin
        last_idx <= win_idx;
        last_vld <= 1'b1;
      end
    end
  end

  assign gnt     = gnt_q;
  assign gnt_alt = gnt_alt_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N    = 4,
  parameter int DUAL = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic         alt_req,
  input logic         xfer_done,
  input logic [N-1:0] gnt,
  input logic         gnt_alt
);
  logic [N-1:0] asking;
  assign asking = req | (N'(alt_req) << DUAL);

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gnt == '0) && !gnt_alt);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((|gnt) && !xfer_done) |=> (gnt == $past(gnt)) && (gnt_alt == $past(gnt_alt)));

  p_switch_r6: assert property (@(posedge clk) disable iff (rst)
    ((|gnt) && xfer_done && (|(asking & ~gnt))) |=> (gnt != $past(gnt)));

  p_again_r7: assert property (@(posedge clk) disable iff (rst)
    ((|gnt) && xfer_done && (asking == gnt)) |=> (gnt == $past(gnt)));

  p_wake_r8: assert property (@(posedge clk) disable iff (rst)
    ((gnt == '0) && (asking != '0)) |=> (gnt != '0));

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ((gnt == '0) && (asking == '0)) |=> (gnt == '0));

  p_alt_owner_r9: assert property (@(posedge clk) disable iff (rst)
    gnt_alt |-> gnt[DUAL]);
endmodule

bind vram_prio_arbiter arb_checker #(.N(N), .DUAL(DUAL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .alt_req   (alt_req),
  .xfer_done (xfer_done),
  .gnt       (gnt),
  .gnt_alt   (gnt_alt)
);

// File: tb/tb_vram_prio_arbiter.sv
module tb_vram_prio_arbiter;
  localparam int PERIOD = 10;
  localparam int N = 4;
  localparam int PW = 3;
  localparam int DUAL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [PW-1:0] p [N];
  logic alt_req = 1'b0;
  logic [PW-1:0] alt_prio = '0;
  logic done = 1'b0;
  logic [N*PW-1:0] prio_flat;
  logic [N-1:0] gnt;
  logic gnt_alt;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit finished = 0;

  // behavioural model state
  logic [N-1:0] m_gnt = '0;
  logic m_alt = 1'b0;
  int m_last = 0;
  bit m_lastv = 0;

  assign prio_flat = {p[3], p[2], p[1], p[0]};

  vram_prio_arbiter #(.N(N), .PW(PW), .DUAL(DUAL)) dut (
    .clk(clk), .rst(rst), .req(req), .prio(prio_flat),
    .alt_req(alt_req), .alt_prio(alt_prio), .xfer_done(done),
    .gnt(gnt), .gnt_alt(gnt_alt));

  always #(PERIOD/2) clk = ~clk;

  function automatic bit asks(int i);
    return (i == DUAL) ? (req[i] | alt_req) : req[i];
  endfunction
  function automatic bit takes_alt(int i);
    return (i == DUAL) && alt_req && (!req[i] || alt_prio > p[i]);
  endfunction
  function automatic int level(int i);
    return takes_alt(i) ? int'(alt_prio) : int'(p[i]);
  endfunction

  always @(posedge clk) begin
    int best;
    if (rst) begin
      m_gnt = '0; m_alt = 0; m_lastv = 0; m_last = 0;
    end else if (m_gnt == '0 || done) begin
      best = -1;
      for (int i = 0; i < N; i++)
        if (asks(i) && !(m_lastv && i == m_last))
          if (best < 0 || level(i) > level(best)) best = i;
      if (best < 0 && m_lastv && asks(m_last)) best = m_last;
      if (best < 0) begin
        m_gnt = '0; m_alt = 0;
      end else begin
        m_gnt = '0; m_gnt[best] = 1'b1;
        m_alt = takes_alt(best);
        m_last = best; m_lastv = 1;
      end
    end
  end

  // model comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      total++;
      if (gnt !== m_gnt || gnt_alt !== m_alt) begin
        bad++;
        $display("FAIL %s cycle model: gnt=%b alt=%b expected gnt=%b alt=%b",
                 tag, gnt, gnt_alt, m_gnt, m_alt);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_done();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic chk(string r, logic [N-1:0] eg, logic ea);
    total++;
    if (gnt !== eg || gnt_alt !== ea) begin
      bad++;
      $display("FAIL %s: gnt=%b alt=%b expected gnt=%b alt=%b", r, gnt, gnt_alt, eg, ea);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog: expired expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) p[i] = '0;
    tick(); tick();
    chk("R1", 4'b0000, 1'b0);
    rst = 1'b0;
    tick();
    chk("R1", 4'b0000, 1'b0);

    // R8: idle request is granted one cycle later
    tag = "R8";
    req = 4'b0100; p[2] = 3;
    tick();
    chk("R8", 4'b0100, 1'b0);

    // R3: a more urgent client cannot pre-empt
    tag = "R3";
    req = 4'b0101; p[0] = 7;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3", 4'b0100, 1'b0);
    end

    // R4: at done the highest other requester wins
    tag = "R4";
    pulse_done();
    chk("R4", 4'b0001, 1'b0);

    // R7: only the last served client asks, it keeps the port
    tag = "R7";
    req = 4'b0001;
    pulse_done();
    chk("R7", 4'b0001, 1'b0);

    // R8: nobody asks at done -> port released
    tag = "R8";
    req = 4'b0000;
    pulse_done();
    chk("R8", 4'b0000, 1'b0);

    // R10: done while idle changes nothing
    tag = "R10";
    pulse_done();
    chk("R10", 4'b0000, 1'b0);

    // R5: tie goes to the lower index
    tag = "R5";
    req = 4'b0110; p[1] = 5; p[2] = 5;
    tick();
    chk("R5", 4'b0010, 1'b0);

    // R6: two most urgent clients alternate, client 2 starves
    tag = "R6";
    req = 4'b0111; p[0] = 7; p[1] = 6; p[2] = 2;
    pulse_done(); chk("R6", 4'b0001, 1'b0);
    pulse_done(); chk("R6", 4'b0010, 1'b0);
    pulse_done(); chk("R6", 4'b0001, 1'b0);
    pulse_done(); chk("R6", 4'b0010, 1'b0);

    // R4: priorities changed during a transfer count at the decision
    tag = "R4";
    p[0] = 1; p[2] = 7;
    tick();
    chk("R3", 4'b0010, 1'b0);
    pulse_done();
    chk("R4", 4'b0100, 1'b0);

    // R9: dual client merged priority and kind
    tag = "R9";
    req = 4'b0000;
    pulse_done();
    chk("R8", 4'b0000, 1'b0);
    req = 4'b1001; p[0] = 4; p[3] = 2; alt_req = 1; alt_prio = 6;
    tick();
    chk("R9", 4'b1000, 1'b1);
    pulse_done();
    chk("R9", 4'b0001, 1'b0);
    req = 4'b1000; p[3] = 6;
    pulse_done();
    chk("R9", 4'b1000, 1'b0);
    req = 4'b0000; alt_prio = 1;
    pulse_done();
    chk("R9", 4'b1000, 1'b1);
    alt_req = 0;
    pulse_done();
    chk("R8", 4'b0000, 1'b0);

    // random traffic checked against the model every cycle (R2..R9)
    tag = "R2";
    for (int k = 0; k < 400; k++) begin
      req = N'($urandom);
      alt_req = 1'($urandom);
      alt_prio = PW'($urandom);
      for (int i = 0; i < N; i++) p[i] = PW'($urandom);
      done = (($urandom % 3) == 0);
      tick();
    end
    done = 0; req = '0; alt_req = 0;
    tick(); tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule